// File: doc/BRIEF.md
# Byte-Addressed Word Stack Engine

This block performs 16-bit stack pushes and pops against a byte-wide synchronous RAM. It keeps a 16-bit stack pointer and a 16-bit stack segment. Every RAM access goes to the physical address segment × 16 + offset, truncated to 20 bits. The offset itself is formed modulo 2^16, so stack traffic never leaves its segment. A client issues one command at a time over a valid/ready handshake. A push carries a data word. A pop returns a word on `pop_data`, marked by a single-cycle `pop_valid` pulse.

A push is split into two byte writes: the high byte goes to SP−1 and then the low byte goes to SP−2, after which SP drops by 2. A pop reads the low byte at SP and then the high byte at SP+1. The RAM answers one cycle after each read. SP then rises by 2, and the word is presented in the following cycle. Software-style set-up is done with two load strobes, one for the pointer and one for the segment. These strobes take effect only while the engine is idle.

The controller has seven states, each named after its memory action:
- `ST_IDLE`: waits for a command or a load.
- `ST_PUSH_HI`: writes the high byte.
- `ST_PUSH_LO`: writes the low byte and steps SP down.
- `ST_POP_LO`: reads the low byte.
- `ST_POP_HI`: reads the high byte and captures the low byte.
- `ST_POP_CAP`: captures the high byte and steps SP up.
- `ST_POP_OUT`: drives the result pulse.

The transitions are:
- `ST_IDLE` goes to `ST_PUSH_HI` on an accepted push.
- `ST_IDLE` goes to `ST_POP_LO` on an accepted pop.
- The push path runs `ST_PUSH_HI` → `ST_PUSH_LO` → `ST_IDLE`.
- The pop path runs `ST_POP_LO` → `ST_POP_HI` → `ST_POP_CAP` → `ST_POP_OUT` → `ST_IDLE`.
- `ST_IDLE` stays in `ST_IDLE` otherwise.

Top module: `wstack_engine`

## Requirements
- R1: After reset, `sp_out` is 0000h, the segment is 0000h, `cmd_ready` is 1, and both `mem_en` and `pop_valid` are 0.
- R2: Every RAM access uses the address (segment × 16 + offset) mod 2^20.
- R3: An accepted push (`cmd_push`=1) writes `cmd_wdata[15:8]` at offset SP−1 in the first cycle after acceptance. It writes `cmd_wdata[7:0]` at offset SP−2 in the second cycle. Both cycles have `mem_en`=1 and `mem_we`=1.
- R4: After a push, `sp_out` equals the old SP−2 from the third cycle after acceptance. `cmd_ready` is 1 again in that cycle.
- R5: An accepted pop (`cmd_push`=0) reads at offset SP in the first cycle and at SP+1 in the second cycle, with `mem_we`=0. `mem_en` is 0 in the third cycle.
- R6: In the fourth cycle after a pop is accepted, `pop_valid` is 1 for exactly one cycle. In that cycle `pop_data` = {byte read at SP+1, byte read at SP}. Words come back last-in first-out.
- R7: Offsets wrap modulo 2^16 inside the segment. With SP=0000h a push writes offsets FFFFh and FFFEh. With SP=FFFFh a pop reads offsets FFFFh and 0000h.
- R8: `cmd_ready` is 0 while an operation is in progress and in any idle cycle with a load strobe high. A `cmd_valid` seen while `cmd_ready` is 0 is ignored.
- R9: In an idle cycle, `sp_load` sets SP to `sp_value` and `ss_load` sets the segment to `ss_value`, both visible from the next cycle. Load strobes during an operation are ignored.
- R10: After a pop, `sp_out` equals the old SP+2 in the cycle where `pop_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_push | input | 1 | 1 = push, 0 = pop |
| cmd_wdata | input | 16 | Word to push |
| sp_load | input | 1 | Load stack pointer strobe |
| sp_value | input | 16 | New stack pointer |
| ss_load | input | 1 | Load stack segment strobe |
| ss_value | input | 16 | New stack segment |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 20 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after the read |
| pop_valid | output | 1 | Popped word valid pulse |
| pop_data | output | 16 | Popped word |
| sp_out | output | 16 | Current stack pointer |

## Verification
Counting from the edge that accepts a command:
- Push byte writes appear in cycles 1 and 2, and the lowered pointer with `cmd_ready` back high appears in cycle 3.
- Pop reads appear in cycles 1 and 2, cycle 3 is quiet, and the result pulse with the raised pointer appears in cycle 4.
- Loads show on `sp_out` one cycle after the strobe.

The bench drives inputs on falling edges and checks each result on the falling edge of exactly the cycle where it is due. It also checks that the pulse and the access lines are quiet in the cycles on either side. A sweep over segment values 0000h, 1234h and FFFFh and pointer values 0000h, 0001h, 0002h, 8000h and FFFFh covers both address wraps.

// File: rtl/wstack_pkg.sv
package wstack_pkg;

    // bytes in one stack word; SP moves by this amount
    localparam int WORD_BYTES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_CAP,
        ST_POP_OUT
    } wst_state_t;

    // offset applied to SP for the current memory access
    typedef enum logic [1:0] {
        OFS_ZERO,
        OFS_PLUS1,
        OFS_MINUS1,
        OFS_MINUS2
    } ofs_sel_t;

endpackage

// File: rtl/wstack_addr.sv
module wstack_addr
    import wstack_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
    input  logic [PTR_W-1:0]  sp,
    input  logic [SEG_W-1:0]  ss,
    input  ofs_sel_t          ofs_sel,
    output logic [ADDR_W-1:0] addr
);

    logic [PTR_W-1:0]  delta;
    logic [PTR_W-1:0]  offset;
    logic [ADDR_W-1:0] base;

    always_comb begin
        unique case (ofs_sel)
            OFS_ZERO:   delta = '0;
            OFS_PLUS1:  delta = PTR_W'(1);
            OFS_MINUS1: delta = '1;
            OFS_MINUS2: delta = ~PTR_W'(1);
            default:    delta = '0;
        endcase
    end

    // offset stays inside the segment: PTR_W-bit wrap
    assign offset = sp + delta;

    generate
        if (SEG_SHIFT > 0) begin : g_shifted
            assign base = {ss, {SEG_SHIFT{1'b0}}};
        end else begin : g_flat
            assign base = ss;
        end
    endgenerate

    assign addr = base + ADDR_W'(offset);

endmodule

// File: rtl/wstack_regs.sv
module wstack_regs
    import wstack_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             sp_load,
    input  logic [PTR_W-1:0] sp_value,
    input  logic             ss_load,
    input  logic [SEG_W-1:0] ss_value,
    input  logic             sp_dec,
    input  logic             sp_inc,
    output logic [PTR_W-1:0] sp,
    output logic [SEG_W-1:0] ss
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (sp_dec) begin
            sp <= sp - STEP;
        end else if (sp_inc) begin
            sp <= sp + STEP;
        end else if (idle && sp_load) begin
            sp <= sp_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss <= '0;
        end else if (idle && ss_load) begin
            ss <= ss_value;
        end
    end

    // R9
    sp_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !sp_dec && !sp_inc) |=> $stable(sp));

    // R9
    ss_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(ss));

endmodule

// File: rtl/wstack_ctrl.sv
module wstack_ctrl
    import wstack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_push,
    input  logic       sp_load,
    input  logic       ss_load,
    output wst_state_t state,
    output logic       idle,
    output logic       cmd_ready,
    output logic       accept,
    output logic       mem_en,
    output logic       mem_we,
    output logic       wr_hi,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       sp_dec,
    output logic       sp_inc,
    output logic       pop_valid,
    output ofs_sel_t   ofs_sel
);

    wst_state_t state_nx;

    assign idle      = (state == ST_IDLE);
    assign cmd_ready = idle && !sp_load && !ss_load;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = cmd_push ? ST_PUSH_HI : ST_POP_LO;
            ST_PUSH_HI: state_nx = ST_PUSH_LO;
            ST_PUSH_LO: state_nx = ST_IDLE;
            ST_POP_LO:  state_nx = ST_POP_HI;
            ST_POP_HI:  state_nx = ST_POP_CAP;
            ST_POP_CAP: state_nx = ST_POP_OUT;
            ST_POP_OUT: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        wr_hi     = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        pop_valid = 1'b0;
        ofs_sel   = OFS_ZERO;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH_HI: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                wr_hi   = 1'b1;
                ofs_sel = OFS_MINUS1;
            end
            ST_PUSH_LO: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                ofs_sel = OFS_MINUS2;
                sp_dec  = 1'b1;
            end
            ST_POP_LO: begin
                mem_en  = 1'b1;
                ofs_sel = OFS_ZERO;
            end
            ST_POP_HI: begin
                mem_en  = 1'b1;
                ofs_sel = OFS_PLUS1;
                cap_lo  = 1'b1;
            end
            ST_POP_CAP: begin
                cap_hi  = 1'b1;
                sp_inc  = 1'b1;
            end
            ST_POP_OUT: pop_valid = 1'b1;
            default: ;
        endcase
    end

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (state == ST_IDLE));

    // R3
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |=> (state == ST_PUSH_LO));

    // R5
    pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_LO) |=> (state == ST_POP_HI));

    // R6
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid);

endmodule

// File: rtl/wstack_engine.sv
module wstack_engine
    import wstack_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int BYTE_W    = 8,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT,
    localparam int WORD_W   = BYTE_W * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_push,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              sp_load,
    input  logic [PTR_W-1:0]  sp_value,
    input  logic              ss_load,
    input  logic [SEG_W-1:0]  ss_value,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              pop_valid,
    output logic [WORD_W-1:0] pop_data,
    output logic [PTR_W-1:0]  sp_out
);

    wst_state_t        state;
    ofs_sel_t          ofs_sel;
    logic              idle, accept, wr_hi, cap_lo, cap_hi, sp_dec, sp_inc;
    logic [PTR_W-1:0]  sp;
    logic [SEG_W-1:0]  ss;
    logic [WORD_W-1:0] wdata_q;
    logic [BYTE_W-1:0] lo_q, hi_q;

    wstack_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_push  (cmd_push),
        .sp_load   (sp_load),
        .ss_load   (ss_load),
        .state     (state),
        .idle      (idle),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .wr_hi     (wr_hi),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc),
        .pop_valid (pop_valid),
        .ofs_sel   (ofs_sel)
    );

    wstack_regs #(.PTR_W(PTR_W), .SEG_W(SEG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .sp_load  (sp_load),
        .sp_value (sp_value),
        .ss_load  (ss_load),
        .ss_value (ss_value),
        .sp_dec   (sp_dec),
        .sp_inc   (sp_inc),
        .sp       (sp),
        .ss       (ss)
    );

    wstack_addr #(.PTR_W(PTR_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
        .sp      (sp),
        .ss      (ss),
        .ofs_sel (ofs_sel),
        .addr    (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      wdata_q <= '0;
        else if (accept) wdata_q <= cmd_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= mem_rdata;
            if (cap_hi) hi_q <= mem_rdata;
        end
    end

    assign mem_wdata = wr_hi ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
    assign pop_data  = {hi_q, lo_q};
    assign sp_out    = sp;

    // R3
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R4
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PUSH_LO) |-> (sp_out == PTR_W'($past(sp_out) - PTR_W'(WORD_BYTES))));

    // R10
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (sp_out == PTR_W'($past(sp_out) + PTR_W'(WORD_BYTES))));

    // R6
    pop_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> !mem_en);

endmodule

// File: tb/sim_wstack_engine.sv
module sim_wstack_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_push = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_value = '0;
    logic        ss_load = 1'b0;
    logic [15:0] ss_value = '0;
    logic        mem_en, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        pop_valid;
    logic [15:0] pop_data;
    logic [15:0] sp_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [15:0] exp_sp = '0;
    logic [15:0] exp_ss = '0;
    logic [15:0] lifo [$];
    logic [7:0]  ram [int];

    always #5 clk = ~clk;

    wstack_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_push(cmd_push), .cmd_wdata(cmd_wdata), .sp_load(sp_load),
        .sp_value(sp_value), .ss_load(ss_load), .ss_value(ss_value),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pop_valid(pop_valid),
        .pop_data(pop_data), .sp_out(sp_out)
    );

    // byte RAM with one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // call at a falling edge
    task automatic load_regs(input logic [15:0] s, input logic [15:0] p);
        sp_load = 1'b1; sp_value = p;
        ss_load = 1'b1; ss_value = s;
        cmd_valid = 1'b1; cmd_push = 1'b0;
        #1 chk("R8", "ready low during load", 32'(cmd_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        sp_load = 1'b0; ss_load = 1'b0; cmd_valid = 1'b0;
        exp_sp = p; exp_ss = s;
        chk("R9", "sp after load", 32'(sp_out), 32'(p));
        chk("R8", "no access from ignored command", 32'(mem_en), 32'd0);
    endtask

    task automatic do_push(input logic [15:0] w);
        cmd_valid = 1'b1; cmd_push = 1'b1; cmd_wdata = w;
        #1 chk("R8", "ready before push", 32'(cmd_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3", "hi we", 32'({mem_en, mem_we}), 32'd3);
        chk("R3", "hi addr (R2 R7)", 32'(mem_addr), 32'(phys(exp_ss, exp_sp - 16'd1)));
        chk("R3", "hi byte", 32'(mem_wdata), 32'(w[15:8]));
        chk("R8", "ready busy", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R3", "lo we", 32'({mem_en, mem_we}), 32'd3);
        chk("R3", "lo addr (R2 R7)", 32'(mem_addr), 32'(phys(exp_ss, exp_sp - 16'd2)));
        chk("R3", "lo byte", 32'(mem_wdata), 32'(w[7:0]));
        @(negedge clk);
        exp_sp = exp_sp - 16'd2;
        chk("R4", "sp after push", 32'(sp_out), 32'(exp_sp));
        chk("R4", "ready after push", 32'(cmd_ready), 32'd1);
        chk("R4", "mem idle", 32'(mem_en), 32'd0);
        lifo.push_back(w);
    endtask

    task automatic do_pop(input logic [15:0] w);
        cmd_valid = 1'b1; cmd_push = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R5", "lo read en", 32'({mem_en, mem_we}), 32'd2);
        chk("R5", "lo addr (R2 R7)", 32'(mem_addr), 32'(phys(exp_ss, exp_sp)));
        @(negedge clk);
        chk("R5", "hi read en", 32'({mem_en, mem_we}), 32'd2);
        chk("R5", "hi addr (R2 R7)", 32'(mem_addr), 32'(phys(exp_ss, exp_sp + 16'd1)));
        @(negedge clk);
        chk("R5", "quiet third cycle", 32'(mem_en), 32'd0);
        chk("R6", "no early valid", 32'(pop_valid), 32'd0);
        chk("R8", "ready busy", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        exp_sp = exp_sp + 16'd2;
        chk("R6", "valid pulse", 32'(pop_valid), 32'd1);
        chk("R6", "pop data", 32'(pop_data), 32'(w));
        chk("R10", "sp after pop", 32'(sp_out), 32'(exp_sp));
        @(negedge clk);
        chk("R6", "pulse ends", 32'(pop_valid), 32'd0);
        chk("R8", "ready after pop", 32'(cmd_ready), 32'd1);
    endtask

    task automatic pop_lifo();
        logic [15:0] w;
        w = lifo.pop_back();
        do_pop(w);
    endtask

    initial begin
        logic [15:0] ss_set [3];
        logic [15:0] sp_set [5];
        ss_set = '{16'h0000, 16'h1234, 16'hFFFF};
        sp_set = '{16'h0000, 16'h0001, 16'h0002, 16'h8000, 16'hFFFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset sp", 32'(sp_out), 32'd0);
        chk("R1", "reset ready", 32'(cmd_ready), 32'd1);
        chk("R1", "reset mem_en", 32'(mem_en), 32'd0);
        chk("R1", "reset pop_valid", 32'(pop_valid), 32'd0);

        // R7: from reset, push lands at FFFFh/FFFEh of segment 0
        do_push(16'hBEEF);
        do_push(16'h0102);
        pop_lifo();
        pop_lifo();
        chk("R7", "ram FFFF", 32'(ram[int'(20'h0FFFF)]), 32'hBE);
        chk("R7", "ram FFFE", 32'(ram[int'(20'h0FFFE)]), 32'hEF);

        // sweep segments and pointers
        foreach (ss_set[i]) begin
            foreach (sp_set[j]) begin
                load_regs(ss_set[i], sp_set[j]);
                do_push(ss_set[i] ^ sp_set[j] ^ 16'h5A3C);
                do_push(~(ss_set[i] + sp_set[j]));
                pop_lifo();
                pop_lifo();
                chk("R10", "sp restored", 32'(sp_out), 32'(sp_set[j]));
            end
        end

        // R7: pop across the offset wrap from preloaded bytes
        load_regs(16'h2000, 16'hFFFF);
        ram[int'(phys(16'h2000, 16'hFFFF))] = 8'h5A;
        ram[int'(phys(16'h2000, 16'h0000))] = 8'hC3;
        do_pop(16'hC35A);

        // R8/R9: command and loads during a push are ignored
        load_regs(16'h0400, 16'h0100);
        cmd_valid = 1'b1; cmd_push = 1'b1; cmd_wdata = 16'hA55A;
        @(posedge clk);
        @(negedge clk);
        cmd_push = 1'b0;
        sp_load = 1'b1; sp_value = 16'h1234;
        ss_load = 1'b1; ss_value = 16'hABCD;
        chk("R3", "hi addr during noise", 32'(mem_addr), 32'(phys(16'h0400, 16'h00FF)));
        chk("R8", "ready low busy", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R9", "lo addr keeps segment", 32'(mem_addr), 32'(phys(16'h0400, 16'h00FE)));
        cmd_valid = 1'b0; sp_load = 1'b0; ss_load = 1'b0;
        @(negedge clk);
        exp_sp = 16'h00FE;
        chk("R9", "sp load ignored while busy", 32'(sp_out), 32'h00FE);
        chk("R8", "no pop started", 32'(mem_en), 32'd0);
        @(negedge clk);
        chk("R8", "still no access", 32'(mem_en), 32'd0);
        lifo.push_back(16'hA55A);
        pop_lifo();

        finish_run();
    end

endmodule